// File: doc/BRIEF.md
# Two-Operand ALU Opcode and ModR/M Decoder

This block sits at the front of a small instruction pipeline. It accepts an instruction byte stream one byte at a time over a valid/ready handshake. It recognises the eight classic two-operand arithmetic and logic opcode groups found in the low quarter of the single-byte opcode space. For each instruction it takes the opcode byte, then the ModR/M byte, then consumes and discards any displacement bytes that 16-bit addressing calls for. It then presents one decoded record, which names:

- the operation;
- the operand size;
- the destination operand and the source operand, each as a register number or a memory reference;
- the displacement length.

The opcode's direction bit decides which ModR/M field is the destination. As a result, two different byte sequences can describe the same register-to-register operation, and both produce the same record. An opcode outside the supported set raises a one-cycle error pulse. The decoder then treats the following byte as a fresh opcode. A record is held until the consumer takes it, and no input byte is accepted while a record is pending.

Top module: `alu_modrm_decoder`

## Requirements
- R1: After reset the decoder waits for an opcode byte: `in_ready` is 1, `rec_valid` is 0 and `err_unsup` is 0.
- R2: A byte taken as an opcode is supported only when its bits 7:6 are 00 and its bits 2:0 are in 0..3. Any other opcode sets `err_unsup` for exactly the cycle after the byte is accepted, and produces no record.
- R3: `rec_op` equals opcode bits 5:3, with this encoding: 0 ADD, 1 OR, 2 ADC, 3 SBB, 4 AND, 5 SUB, 6 XOR, 7 CMP.
- R4: `rec_wide` equals opcode bit 0. A value of 0 means byte operands and 1 means word/dword operands.
- R5: Opcode bit 1 is the direction bit. When it is 0, the destination is the r/m operand (ModR/M bits 2:0) and the source is the reg field (ModR/M bits 5:3). When it is 1, the destination is the reg field and the source is the r/m operand.
- R6: The mod field is ModR/M bits 7:6. When mod is not 3, the r/m operand is memory and its `*_mem` flag is 1; its register-number output still carries ModR/M bits 2:0. The reg-field operand is never memory, so at most one operand is memory.
- R7: The byte pairs 31h C1h and 33h C8h both yield the same record: op XOR (6), wide 1, destination register 1, source register 0, neither operand memory.
- R8: The displacement length is 1 when mod is 1, and 2 when mod is 2. It is also 2 when mod is 0 and r/m is 6, and 0 in every other case. That many following bytes are consumed without effect (no error, no record), and the record appears right after the last of them.
- R9: A record stays valid with all fields unchanged until `rec_ready` is 1 at a clock edge. While it is pending, `in_ready` is 0.
- R10: After an unsupported opcode, the next accepted byte is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| rec_valid | output | 1 | Decoded record is pending |
| rec_ready | input | 1 | Consumer takes the record |
| rec_op | output | 3 | Operation code |
| rec_wide | output | 1 | 1 = word/dword operands, 0 = byte |
| rec_dst_mem | output | 1 | Destination is memory |
| rec_dst_reg | output | 3 | Destination register number (r/m code when memory) |
| rec_src_mem | output | 1 | Source is memory |
| rec_src_reg | output | 3 | Source register number (r/m code when memory) |
| rec_disp_len | output | 2 | Displacement byte count |
| err_unsup | output | 1 | One-cycle pulse on an unsupported opcode |

## Verification
The hardest situation to reach from the ports is a displacement byte whose value would be an unsupported opcode if it were mistaken for one. The stimulus therefore sends FFh as every displacement byte. A miscounted skip then shows up as an error pulse, or as a record that arrives too early or too late. A second hard case is an input byte offered while a record is stalled. The bench holds `rec_ready` low, drives an unsupported opcode on the input for several cycles, and checks that neither the held record nor the error output reacts.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;
   localparam int REG_W  = 3;
   localparam int DLEN_W = 2;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0, OP_OR  = 3'd1, OP_ADC = 3'd2, OP_SBB = 3'd3,
      OP_AND = 3'd4, OP_SUB = 3'd5, OP_XOR = 3'd6, OP_CMP = 3'd7
   } alu_op_e;

   typedef struct packed {
      alu_op_e           op;
      logic              wide;
      logic              dst_mem;
      logic [REG_W-1:0]  dst_reg;
      logic              src_mem;
      logic [REG_W-1:0]  src_reg;
      logic [DLEN_W-1:0] disp_len;
   } dec_rec_t;
endpackage

// File: rtl/alu_opc_classify.sv
module alu_opc_classify
   import alu_dec_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int LOW_MAX  = 3
) (
   input  logic [BYTE_W-1:0] opc,
   output logic              supported,
   output alu_op_e           op,
   output logic              wide,
   output logic              dir
);
   localparam logic [2:0] LOW_LIM = 3'(LOW_MAX);

   if (LOW_MAX < 0 || LOW_MAX > 3) begin : g_bad_low
      $error("LOW_MAX must lie in 0..3");
   end

   always_comb begin
      supported = (opc[7:6] == 2'b00) && (opc[2:0] <= LOW_LIM);
      op        = alu_op_e'(opc[5:3]);
      wide      = opc[0];
      dir       = opc[1];
   end
endmodule

// File: rtl/alu_modrm_map.sv
module alu_modrm_map
   import alu_dec_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] modrm,
   input  logic              dir,
   output logic              dst_mem,
   output logic [REG_W-1:0]  dst_reg,
   output logic              src_mem,
   output logic [REG_W-1:0]  src_reg,
   output logic [DLEN_W-1:0] disp_len
);
   logic [1:0]       mod_f;
   logic [REG_W-1:0] reg_f;
   logic [REG_W-1:0] rm_f;
   logic             rm_is_mem;

   always_comb begin
      mod_f     = modrm[7:6];
      reg_f     = modrm[5:3];
      rm_f      = modrm[2:0];
      rm_is_mem = (mod_f != 2'd3);
      if (dir) begin
         dst_mem = 1'b0;      dst_reg = reg_f;
         src_mem = rm_is_mem; src_reg = rm_f;
      end else begin
         dst_mem = rm_is_mem; dst_reg = rm_f;
         src_mem = 1'b0;      src_reg = reg_f;
      end
      case (mod_f)
         2'd1:    disp_len = 2'd1;
         2'd2:    disp_len = 2'd2;
         2'd0:    disp_len = (rm_f == 3'd6) ? 2'd2 : 2'd0;
         default: disp_len = 2'd0;
      endcase
   end

   // R6: the reg field never names memory
   always_comb begin
      assert_one_mem_R6: assert (!(dst_mem && src_mem))
         else $error("both operands marked memory");
   end
endmodule

// File: rtl/alu_dec_seq.sv
module alu_dec_seq
   import alu_dec_pkg::*;
#(
   parameter bit ERR_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_valid,
   output logic     in_ready,
   input  logic     opc_ok,
   input  alu_op_e  opc_op,
   input  logic     opc_wide,
   input  logic     opc_dir,
   input  dec_rec_t mapped,
   output logic     dir_q,
   output logic     rec_valid,
   input  logic     rec_ready,
   output dec_rec_t rec,
   output logic     err_unsup
);
   typedef enum logic [1:0] {S_OPC, S_MODRM, S_DISP, S_OUT} st_e;

   st_e             state;
   logic [DLEN_W-1:0] cnt;
   alu_op_e         op_q;
   logic            wide_q;
   dec_rec_t        rec_q;
   logic            take;
   logic            bad_now;

   assign in_ready  = (state != S_OUT);
   assign take      = in_valid && in_ready;
   assign bad_now   = take && (state == S_OPC) && !opc_ok;
   assign rec_valid = (state == S_OUT);
   assign rec       = rec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_OPC;
         cnt    <= '0;
         op_q   <= OP_ADD;
         wide_q <= 1'b0;
         dir_q  <= 1'b0;
         rec_q  <= '0;
      end else begin
         case (state)
            S_OPC: if (take && opc_ok) begin
               op_q   <= opc_op;
               wide_q <= opc_wide;
               dir_q  <= opc_dir;
               state  <= S_MODRM;
            end
            S_MODRM: if (take) begin
               rec_q      <= mapped;
               rec_q.op   <= op_q;
               rec_q.wide <= wide_q;
               cnt        <= mapped.disp_len;
               state      <= (mapped.disp_len == '0) ? S_OUT : S_DISP;
            end
            S_DISP: if (take) begin
               cnt <= cnt - 1'b1;
               if (cnt == DLEN_W'(1)) state <= S_OUT;
            end
            default: if (rec_ready) state <= S_OPC;
         endcase
      end
   end

   if (ERR_REG) begin : g_err_reg
      logic err_q;
      always_ff @(posedge clk) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= bad_now;
      end
      assign err_unsup = err_q;
   end else begin : g_err_comb
      assign err_unsup = bad_now;
   end

   // R9: pending record is held unchanged
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec));
   // R9: no byte taken while pending
   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !in_ready);
   // R2: an error is never followed at once by a record
   assert_err_norec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_unsup |-> !rec_valid);
   // R8: record only appears right after a byte is consumed
   assert_rec_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_valid) |-> $past(in_valid));
   // R8: displacement length legal
   assert_disp_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> rec.disp_len != 2'd3);
endmodule

// File: rtl/alu_modrm_decoder.sv
module alu_modrm_decoder
   import alu_dec_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int LOW_MAX = 3,
   parameter bit ERR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic [2:0]        rec_op,
   output logic              rec_wide,
   output logic              rec_dst_mem,
   output logic [REG_W-1:0]  rec_dst_reg,
   output logic              rec_src_mem,
   output logic [REG_W-1:0]  rec_src_reg,
   output logic [DLEN_W-1:0] rec_disp_len,
   output logic              err_unsup
);
   if (BYTE_W != 8) begin : g_bad_width
      $error("BYTE_W must be 8");
   end

   logic     opc_ok, opc_wide, opc_dir, dir_q;
   alu_op_e  opc_op;
   dec_rec_t mapped, rec;

   alu_opc_classify #(.BYTE_W(BYTE_W), .LOW_MAX(LOW_MAX)) u_cls (
      .opc(in_data), .supported(opc_ok), .op(opc_op),
      .wide(opc_wide), .dir(opc_dir));

   always_comb begin
      mapped.op   = OP_ADD;
      mapped.wide = 1'b0;
   end

   alu_modrm_map #(.BYTE_W(BYTE_W)) u_map (
      .modrm(in_data), .dir(dir_q),
      .dst_mem(mapped.dst_mem), .dst_reg(mapped.dst_reg),
      .src_mem(mapped.src_mem), .src_reg(mapped.src_reg),
      .disp_len(mapped.disp_len));

   alu_dec_seq #(.ERR_REG(ERR_REG)) u_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .opc_ok(opc_ok), .opc_op(opc_op), .opc_wide(opc_wide), .opc_dir(opc_dir),
      .mapped(mapped), .dir_q(dir_q), .rec_valid(rec_valid),
      .rec_ready(rec_ready), .rec(rec), .err_unsup(err_unsup));

   assign rec_op       = rec.op;
   assign rec_wide     = rec.wide;
   assign rec_dst_mem  = rec.dst_mem;
   assign rec_dst_reg  = rec.dst_reg;
   assign rec_src_mem  = rec.src_mem;
   assign rec_src_reg  = rec.src_reg;
   assign rec_disp_len = rec.disp_len;

   // R6: at most one memory operand at the ports
   assert_mem_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !(rec_dst_mem && rec_src_mem));
endmodule

// File: tb/alu_modrm_decoder_bench.sv
module alu_modrm_decoder_bench;
   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, rec_ready = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic in_ready, rec_valid, rec_wide, rec_dst_mem, rec_src_mem, err_unsup;
   logic [2:0] rec_op, rec_dst_reg, rec_src_reg;
   logic [1:0] rec_disp_len;
   int total = 0, bad = 0;
   logic last_err;

   always #2 clk = ~clk;

   alu_modrm_decoder u_alu_modrm_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_op(rec_op), .rec_wide(rec_wide), .rec_dst_mem(rec_dst_mem),
      .rec_dst_reg(rec_dst_reg), .rec_src_mem(rec_src_mem),
      .rec_src_reg(rec_src_reg), .rec_disp_len(rec_disp_len),
      .err_unsup(err_unsup));

   // {opcode, modrm, op, wide, dst_mem, dst, src_mem, src, disp_len}
   localparam int NV = 12;
   localparam logic [29:0] VEC [NV] = '{
      {8'h31, 8'hC1, 3'd6, 1'b1, 1'b0, 3'd1, 1'b0, 3'd0, 2'd0},
      {8'h33, 8'hC8, 3'd6, 1'b1, 1'b0, 3'd1, 1'b0, 3'd0, 2'd0},
      {8'h30, 8'hD8, 3'd6, 1'b0, 1'b0, 3'd0, 1'b0, 3'd3, 2'd0},
      {8'h29, 8'h45, 3'd5, 1'b1, 1'b1, 3'd5, 1'b0, 3'd0, 2'd1},
      {8'h2B, 8'h86, 3'd5, 1'b1, 1'b0, 3'd0, 1'b1, 3'd6, 2'd2},
      {8'h02, 8'h06, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd6, 2'd2},
      {8'h38, 8'h07, 3'd7, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 2'd0},
      {8'h11, 8'hFB, 3'd2, 1'b1, 1'b0, 3'd3, 1'b0, 3'd7, 2'd0},
      {8'h1A, 8'h5C, 3'd3, 1'b0, 1'b0, 3'd3, 1'b1, 3'd4, 2'd1},
      {8'h21, 8'hD1, 3'd4, 1'b1, 1'b0, 3'd1, 1'b0, 3'd2, 2'd0},
      {8'h0B, 8'hC2, 3'd1, 1'b1, 1'b0, 3'd0, 1'b0, 3'd2, 2'd0},
      {8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 2'd0}
   };

   function automatic logic [13:0] act_rec();
      return {rec_op, rec_wide, rec_dst_mem, rec_dst_reg,
              rec_src_mem, rec_src_reg, rec_disp_len};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int w = 0; w < 50 && !in_ready; w++) @(negedge clk);
      in_valid = 1'b1; in_data = b;
      @(negedge clk);
      in_valid = 1'b0;
      last_err = err_unsup;
   endtask

   task automatic take_rec(output logic [13:0] r);
      for (int w = 0; w < 50 && !rec_valid; w++) @(negedge clk);
      r = act_rec();
      check("R9 record valid", {31'd0, rec_valid}, 32'd1);
      rec_ready = 1'b1;
      @(negedge clk);
      rec_ready = 1'b0;
   endtask

   initial begin
      #(4 * 50000);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [13:0] r, r_a, r_b;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 in_ready", {31'd0, in_ready}, 32'd1);
      check("R1 rec_valid", {31'd0, rec_valid}, 32'd0);
      check("R1 err_unsup", {31'd0, err_unsup}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R5 R6 R8: vector walk, FFh as displacement filler
      for (int i = 0; i < NV; i++) begin
         send_byte(VEC[i][29:22]);
         send_byte(VEC[i][21:14]);
         for (int d = 0; d < int'(VEC[i][1:0]); d++) begin
            check("R8 no record before last disp byte", {31'd0, rec_valid}, 32'd0);
            send_byte(8'hFF);
            check("R8 disp byte ignored", {31'd0, last_err}, 32'd0);
         end
         take_rec(r);
         check("R3 R4 R5 R6 R8 record", {18'd0, r}, {18'd0, VEC[i][13:0]});
      end

      // R7: both direction forms give bit-identical records
      send_byte(8'h31); send_byte(8'hC1); take_rec(r_a);
      send_byte(8'h33); send_byte(8'hC8); take_rec(r_b);
      check("R7 forms identical", {18'd0, r_a}, {18'd0, r_b});
      check("R7 xor cx,ax", {18'd0, r_a}, {18'd0, 3'd6, 1'b1, 1'b0, 3'd1, 1'b0, 3'd0, 2'd0});

      // R9: hold while stalled, stalled input byte not taken
      send_byte(8'h29); send_byte(8'hC3);
      r = act_rec();
      in_valid = 1'b1; in_data = 8'h04;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check("R9 held record", {18'd0, act_rec()}, {18'd0, r});
         check("R9 in_ready low", {31'd0, in_ready}, 32'd0);
         check("R9 stalled byte no error", {31'd0, err_unsup}, 32'd0);
      end
      in_valid = 1'b0;
      check("R9 held sub bx,ax", {18'd0, r}, {18'd0, 3'd5, 1'b1, 1'b0, 3'd3, 1'b0, 3'd0, 2'd0});
      take_rec(r);

      // R2 R10: unsupported opcodes, then resynchronise
      foreach (VEC[j]) begin
         logic [7:0] badop;
         if (j > 3) break;
         badop = (j == 0) ? 8'h04 : (j == 1) ? 8'h40 : (j == 2) ? 8'h0F : 8'hC1;
         send_byte(badop);
         check("R2 error pulse", {31'd0, last_err}, 32'd1);
         @(negedge clk);
         check("R2 pulse one cycle", {31'd0, err_unsup}, 32'd0);
         check("R2 no record", {31'd0, rec_valid}, 32'd0);
         send_byte(8'h30); send_byte(8'hC1);
         check("R10 resync no error", {31'd0, last_err}, 32'd0);
         take_rec(r);
         check("R10 record after resync", {18'd0, r},
               {18'd0, 3'd6, 1'b0, 1'b0, 3'd1, 1'b0, 3'd0, 2'd0});
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule